// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block sits between a 32-bit memory-mapped register bus and the bit-level engine of an I2C master. Software writes command words (a byte plus start, stop and direction flags) into a small command queue. The engine drains that queue through a valid/ready handshake. Bytes the engine receives are pushed into a receive queue, and software pops them one at a time through a data register. The block also holds the bus-speed selection and three timing counts, which it drives straight to the engine.

One level-sensitive interrupt line covers five conditions. Two of them are live comparisons of the queue occupancies against programmable thresholds: room for more commands, and received data waiting. The other three are sticky error flags: the peer did not acknowledge, arbitration was lost, and a received byte arrived while the receive queue was full. The enable bit in the control register also acts as a soft reset. While it is clear, both queues are held empty and the engine is offered no commands.

A register read returns its data one clock after the read strobe. A read of an unmapped or write-only offset returns 0.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, all writable registers read 0, both level registers read 0, `irq` and `cmdValid` are low, and the interrupt status register reads 0x1, because the empty command queue meets the TX-ready condition.
- R2: A write to offset 0x00 pushes bits 9:0 of the write data into the command queue. Bit 9 is start, bit 8 is stop and bits 7:0 are data. While enabled, the engine sees the entries in write order on `cmdWord` with `cmdValid` high. One entry is removed on each cycle in which `cmdValid` and `cmdReady` are both high. Offset 0x18 reads the occupancy.
- R3: A command write while the command queue holds `FIFO_DEPTH` entries is dropped. The level stays the same and the queued entries are unchanged.
- R4: An `rxPush` pulse queues `rxByte`. Each read of offset 0x04 returns the oldest byte in bits 7:0 and removes it. Offset 0x1C reads the occupancy.
- R5: A read of offset 0x04 while the receive queue is empty returns 0 and leaves the level at 0.
- R6: An `rxPush` while the receive queue is full drops the byte and sets the sticky RX-overflow flag, which is status bit 4.
- R7: Status bit 0 (TX ready) is 1 while the command level is at or below control bits 3:2. Status bit 1 (RX ready) is 1 while the receive level is above control bits 5:4. Both bits follow the levels with no latching.
- R8: An `evtNack` pulse sets status bit 2 and an `evtArbLost` pulse sets status bit 3. A write to offset 0x10 clears each of bits 4:2 that carries a 1 and leaves bits that carry a 0 untouched.
- R9: `irq` is high exactly when some bit of the status register at 0x10 and the same bit of the enable register at 0x0C are both 1.
- R10: While control bit 0 is 0, both queues are empty, `cmdValid` is low, and command writes and `rxPush` pulses are discarded.
- R11: Bit 0 of offset 0x14 returns the value of `engBusy` at the read strobe.
- R12: Offsets 0x20, 0x24 and 0x28 hold the SCL low, SCL high and SDA hold counts. They read back and drive `sclLowCnt`, `sclHighCnt` and `sdaHoldCnt`. Control bits 1 and 0 drive `fastMode` and `coreEnable`, and the control register reads back in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid the cycle after `regRdEn` |
| cmdValid | output | 1 | Command available to the engine |
| cmdReady | input | 1 | Engine takes the command |
| cmdWord | output | CMD_W | Oldest command: start, stop, data |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| evtNack | input | 1 | Pulse: no acknowledge seen |
| evtArbLost | input | 1 | Pulse: arbitration lost |
| engBusy | input | 1 | Engine is busy |
| coreEnable | output | 1 | Core enable to the engine |
| fastMode | output | 1 | Bus speed select, 1 for fast |
| sclLowCnt | output | CNT_W | SCL low count |
| sclHighCnt | output | CNT_W | SCL high count |
| sdaHoldCnt | output | CNT_W | SDA hold count |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every threshold against every occupancy from 0 to full for both queues. A comparison that is off by one, or that uses the wrong sense, shows up as a wrong ready bit at one exact level. It fills each queue past capacity. A design that wraps its pointers would then overwrite the oldest command or byte, and a design that misses the overflow would leave bit 4 clear. It reads the empty receive queue, which exposes stale data or a level that underflows. It writes zeros and mixed masks to the status register to catch write-to-clear logic that clears unmarked bits or does not clear at all. It also clears the enable bit and then pushes into both queues, which catches a soft reset that does not flush the queues or does not block new entries.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;

  localparam int unsigned OFF_CMD     = 'h00;
  localparam int unsigned OFF_RXDATA  = 'h04;
  localparam int unsigned OFF_CTRL    = 'h08;
  localparam int unsigned OFF_IEN     = 'h0C;
  localparam int unsigned OFF_ISR     = 'h10;
  localparam int unsigned OFF_STAT    = 'h14;
  localparam int unsigned OFF_CMDLVL  = 'h18;
  localparam int unsigned OFF_RXLVL   = 'h1C;
  localparam int unsigned OFF_SCLLO   = 'h20;
  localparam int unsigned OFF_SCLHI   = 'h24;
  localparam int unsigned OFF_HOLD    = 'h28;

  // interrupt bit positions (shared by enable and status)
  localparam int unsigned IRQ_TXRDY = 0;
  localparam int unsigned IRQ_RXRDY = 1;
  localparam int unsigned IRQ_NACK  = 2;
  localparam int unsigned IRQ_ARB   = 3;
  localparam int unsigned IRQ_RXOVF = 4;
  localparam int unsigned IRQ_W     = 5;
  localparam int unsigned CTRL_W    = 6;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RX, SEL_CTRL, SEL_IEN, SEL_ISR, SEL_STAT,
    SEL_CMDLVL, SEL_RXLVL, SEL_SCLLO, SEL_SCLHI, SEL_HOLD
  } regSel_e;

  typedef struct packed {
    logic    wrCmd;
    logic    wrCtrl;
    logic    wrIen;
    logic    wrIsr;
    logic    wrSclLo;
    logic    wrSclHi;
    logic    wrHold;
    logic    rdPop;
    logic    rdEn;
    regSel_e rdSel;
  } regStb_t;

endpackage

// File: rtl/i2c_fifo.sv
module i2c_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign full   = (level == LVL_W'(DEPTH));
  assign empty  = (level == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      if (pushOk && !popOk)      level <= level + 1'b1;
      else if (popOk && !pushOk) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= din;
  end

endmodule

// File: rtl/i2c_regs_ctl.sv
module i2c_regs_ctl
  import i2c_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStb_t           stb
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    stb         = '0;
    stb.rdSel   = SEL_NONE;
    stb.rdEn    = regRdEn;
    stb.wrCmd   = regWrEn && hit(regAddr, OFF_CMD);
    stb.wrCtrl  = regWrEn && hit(regAddr, OFF_CTRL);
    stb.wrIen   = regWrEn && hit(regAddr, OFF_IEN);
    stb.wrIsr   = regWrEn && hit(regAddr, OFF_ISR);
    stb.wrSclLo = regWrEn && hit(regAddr, OFF_SCLLO);
    stb.wrSclHi = regWrEn && hit(regAddr, OFF_SCLHI);
    stb.wrHold  = regWrEn && hit(regAddr, OFF_HOLD);
    stb.rdPop   = regRdEn && hit(regAddr, OFF_RXDATA);
    if (regRdEn) begin
      if      (hit(regAddr, OFF_RXDATA)) stb.rdSel = SEL_RX;
      else if (hit(regAddr, OFF_CTRL))   stb.rdSel = SEL_CTRL;
      else if (hit(regAddr, OFF_IEN))    stb.rdSel = SEL_IEN;
      else if (hit(regAddr, OFF_ISR))    stb.rdSel = SEL_ISR;
      else if (hit(regAddr, OFF_STAT))   stb.rdSel = SEL_STAT;
      else if (hit(regAddr, OFF_CMDLVL)) stb.rdSel = SEL_CMDLVL;
      else if (hit(regAddr, OFF_RXLVL))  stb.rdSel = SEL_RXLVL;
      else if (hit(regAddr, OFF_SCLLO))  stb.rdSel = SEL_SCLLO;
      else if (hit(regAddr, OFF_SCLHI))  stb.rdSel = SEL_SCLHI;
      else if (hit(regAddr, OFF_HOLD))   stb.rdSel = SEL_HOLD;
    end
  end

endmodule

// File: rtl/i2c_regs_dp.sv
module i2c_regs_dp
  import i2c_regs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CMD_W      = 10,
  parameter int CNT_W      = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [CMD_W-1:0]  cmdWord,
  input  logic              rxPush,
  input  logic [7:0]        rxByte,
  input  logic              evtNack,
  input  logic              evtArbLost,
  input  logic              engBusy,
  output logic              coreEnable,
  output logic              fastMode,
  output logic [CNT_W-1:0]  sclLowCnt,
  output logic [CNT_W-1:0]  sclHighCnt,
  output logic [CNT_W-1:0]  sdaHoldCnt,
  output logic [LVL_W-1:0]  cmdLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              irq
);

  logic [CTRL_W-1:0] ctrlReg;
  logic [IRQ_W-1:0]  ienReg;
  logic [2:0]        stickyReg;   // {ovf, arb, nack}
  logic [IRQ_W-1:0]  isrView;
  logic cmdFull, cmdEmpty, rxFull, rxEmpty;
  logic [7:0] rxDout;
  logic txRdy, rxRdy, ovfSet, flush;
  logic [1:0] cmdThr, rxThr;

  assign coreEnable = ctrlReg[0];
  assign fastMode   = ctrlReg[1];
  assign cmdThr     = ctrlReg[3:2];
  assign rxThr      = ctrlReg[5:4];
  assign flush      = !coreEnable;

  i2c_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) cmdQ (
    .clk(clk), .rstN(rstN), .flush(flush),
    .push(stb.wrCmd && coreEnable), .din(wrData[CMD_W-1:0]),
    .pop(cmdValid && cmdReady), .dout(cmdWord),
    .level(cmdLevel), .full(cmdFull), .empty(cmdEmpty)
  );

  i2c_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .flush(flush),
    .push(rxPush && coreEnable), .din(rxByte),
    .pop(stb.rdPop && coreEnable), .dout(rxDout),
    .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );

  assign cmdValid = coreEnable && !cmdEmpty;
  assign txRdy    = cmdLevel <= LVL_W'(cmdThr);
  assign rxRdy    = rxLevel > LVL_W'(rxThr);
  assign ovfSet   = rxPush && coreEnable && rxFull;

  assign isrView = {stickyReg[2], stickyReg[1], stickyReg[0], rxRdy, txRdy};
  assign irq     = |(isrView & ienReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      ienReg     <= '0;
      stickyReg  <= '0;
      sclLowCnt  <= '0;
      sclHighCnt <= '0;
      sdaHoldCnt <= '0;
    end else begin
      if (stb.wrCtrl)  ctrlReg    <= wrData[CTRL_W-1:0];
      if (stb.wrIen)   ienReg     <= wrData[IRQ_W-1:0];
      if (stb.wrSclLo) sclLowCnt  <= wrData[CNT_W-1:0];
      if (stb.wrSclHi) sclHighCnt <= wrData[CNT_W-1:0];
      if (stb.wrHold)  sdaHoldCnt <= wrData[CNT_W-1:0];
      stickyReg <= (stickyReg & ~(stb.wrIsr ? wrData[IRQ_RXOVF:IRQ_NACK] : 3'b000))
                 | {ovfSet, evtArbLost, evtNack};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdEn) begin
      unique case (stb.rdSel)
        SEL_RX:     rdData <= rxEmpty ? '0 : DATA_W'(rxDout);
        SEL_CTRL:   rdData <= DATA_W'(ctrlReg);
        SEL_IEN:    rdData <= DATA_W'(ienReg);
        SEL_ISR:    rdData <= DATA_W'(isrView);
        SEL_STAT:   rdData <= DATA_W'(engBusy);
        SEL_CMDLVL: rdData <= DATA_W'(cmdLevel);
        SEL_RXLVL:  rdData <= DATA_W'(rxLevel);
        SEL_SCLLO:  rdData <= DATA_W'(sclLowCnt);
        SEL_SCLHI:  rdData <= DATA_W'(sclHighCnt);
        SEL_HOLD:   rdData <= DATA_W'(sdaHoldCnt);
        default:    rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_regs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 4,
  parameter int CMD_W      = 10,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [CMD_W-1:0]  cmdWord,
  input  logic              rxPush,
  input  logic [7:0]        rxByte,
  input  logic              evtNack,
  input  logic              evtArbLost,
  input  logic              engBusy,
  output logic              coreEnable,
  output logic              fastMode,
  output logic [CNT_W-1:0]  sclLowCnt,
  output logic [CNT_W-1:0]  sclHighCnt,
  output logic [CNT_W-1:0]  sdaHoldCnt,
  output logic              irq
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  regStb_t           stb;
  logic [LVL_W-1:0]  cmdLevel;
  logic [LVL_W-1:0]  rxLevel;

  i2c_regs_ctl #(.ADDR_W(ADDR_W)) ctlInst (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .stb(stb)
  );

  i2c_regs_dp #(
    .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CMD_W(CMD_W), .CNT_W(CNT_W)
  ) dpInst (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .rdData(regRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord),
    .rxPush(rxPush), .rxByte(rxByte), .evtNack(evtNack), .evtArbLost(evtArbLost),
    .engBusy(engBusy), .coreEnable(coreEnable), .fastMode(fastMode),
    .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt), .sdaHoldCnt(sdaHoldCnt),
    .cmdLevel(cmdLevel), .rxLevel(rxLevel), .irq(irq)
  );

endmodule

// File: rtl/i2c_ctl_regs_chk.sv
module i2c_ctl_regs_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              rxPush,
  input logic              engBusy,
  input logic              coreEnable,
  input logic [LVL_W-1:0]  cmdLevel,
  input logic [LVL_W-1:0]  rxLevel
);

  // R3
  cmd_level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLevel <= LVL_W'(FIFO_DEPTH) && rxLevel <= LVL_W'(FIFO_DEPTH));

  // R2
  cmd_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !regWrEn) |=> cmdLevel == $past(cmdLevel) - 1'b1);

  // R6
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreEnable && rxPush && rxLevel == LVL_W'(FIFO_DEPTH) && !regRdEn && !regWrEn)
      |=> rxLevel == LVL_W'(FIFO_DEPTH));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreEnable) |=> (cmdLevel == '0 && rxLevel == '0));

  // R10
  no_cmd_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coreEnable |-> !cmdValid);

  // R11
  busy_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'('h14)) |=> regRdData[0] == $past(engBusy));

endmodule

bind i2c_ctl_regs i2c_ctl_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) chkInst (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regRdData(regRdData), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .rxPush(rxPush), .engBusy(engBusy),
  .coreEnable(coreEnable), .cmdLevel(cmdLevel), .rxLevel(rxLevel)
);

// File: tb/tb_i2c_ctl_regs.sv
`timescale 1ns/1ps
module tb_i2c_ctl_regs;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmdValid, cmdReady = 1'b0;
  logic [9:0]  cmdWord;
  logic        rxPush = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        evtNack = 1'b0, evtArbLost = 1'b0, engBusy = 1'b0;
  logic        coreEnable, fastMode, irq;
  logic [15:0] sclLowCnt, sclHighCnt, sdaHoldCnt;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  i2c_ctl_regs dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord),
    .rxPush(rxPush), .rxByte(rxByte), .evtNack(evtNack), .evtArbLost(evtArbLost),
    .engBusy(engBusy), .coreEnable(coreEnable), .fastMode(fastMode),
    .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt), .sdaHoldCnt(sdaHoldCnt),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); regRdEn = 1'b0; d = regRdData;
  endtask

  task automatic pushRx(input logic [7:0] b);
    @(negedge clk); rxPush = 1'b1; rxByte = b;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic popCmd(input logic [9:0] exp);
    chk("R2 cmdValid", 32'(cmdValid), 32'd1);
    chk("R2 cmdWord", 32'(cmdWord), 32'(exp));
    cmdReady = 1'b1;
    @(negedge clk); cmdReady = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdData", regRdData, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cmdValid", 32'(cmdValid), 0);
    chk("R1 coreEnable", 32'(coreEnable), 0);
    rdReg(6'h08, rv); chk("R1 ctrl", rv, 0);
    rdReg(6'h0C, rv); chk("R1 ien", rv, 0);
    rdReg(6'h10, rv); chk("R1 isr", rv, 32'h1);
    rdReg(6'h18, rv); chk("R1 cmdlvl", rv, 0);
    rdReg(6'h1C, rv); chk("R1 rxlvl", rv, 0);

    // R12 timing and control
    wrReg(6'h20, 32'h1234);
    wrReg(6'h24, 32'hABCD);
    wrReg(6'h28, 32'h002A);
    wrReg(6'h08, 32'h3);
    chk("R12 sclLow out", 32'(sclLowCnt), 32'h1234);
    chk("R12 sclHigh out", 32'(sclHighCnt), 32'hABCD);
    chk("R12 hold out", 32'(sdaHoldCnt), 32'h2A);
    chk("R12 fastMode", 32'(fastMode), 1);
    chk("R12 coreEnable", 32'(coreEnable), 1);
    rdReg(6'h20, rv); chk("R12 sclLow rd", rv, 32'h1234);
    rdReg(6'h24, rv); chk("R12 sclHigh rd", rv, 32'hABCD);
    rdReg(6'h28, rv); chk("R12 hold rd", rv, 32'h2A);
    rdReg(6'h08, rv); chk("R12 ctrl rd", rv, 32'h3);
    wrReg(6'h08, 32'h1);
    chk("R12 fastMode off", 32'(fastMode), 0);

    // R10 disabled core discards input
    wrReg(6'h00, 32'h155);
    pushRx(8'h77);
    wrReg(6'h08, 32'h0);
    rdReg(6'h18, rv); chk("R10 cmd flushed", rv, 0);
    rdReg(6'h1C, rv); chk("R10 rx flushed", rv, 0);
    wrReg(6'h00, 32'h155);
    pushRx(8'h77);
    chk("R10 cmdValid off", 32'(cmdValid), 0);
    rdReg(6'h18, rv); chk("R10 cmd ignored", rv, 0);
    rdReg(6'h1C, rv); chk("R10 rx ignored", rv, 0);
    wrReg(6'h08, 32'h1);
    rdReg(6'h18, rv); chk("R10 cmd after enable", rv, 0);

    // R2 / R3 command queue
    wrReg(6'h00, 32'h250);
    wrReg(6'h00, 32'h0A1);
    wrReg(6'h00, 32'hFFFF_F3C5);
    wrReg(6'h00, 32'h1A3);
    wrReg(6'h00, 32'h0FF);
    rdReg(6'h18, rv); chk("R3 level full", rv, DEPTH);
    popCmd(10'h250);
    popCmd(10'h0A1);
    popCmd(10'h3C5);
    popCmd(10'h1A3);
    chk("R3 no extra entry", 32'(cmdValid), 0);
    rdReg(6'h18, rv); chk("R2 level drained", rv, 0);

    // R4 / R6 / R5 receive queue
    pushRx(8'h11); pushRx(8'h22); pushRx(8'h33); pushRx(8'h44);
    rdReg(6'h10, rv); chk("R6 no ovf yet", rv & 32'h10, 0);
    pushRx(8'h55);
    rdReg(6'h10, rv); chk("R6 ovf set", rv & 32'h10, 32'h10);
    rdReg(6'h1C, rv); chk("R6 level full", rv, DEPTH);
    rdReg(6'h04, rv); chk("R4 byte0", rv, 32'h11);
    rdReg(6'h04, rv); chk("R4 byte1", rv, 32'h22);
    rdReg(6'h04, rv); chk("R4 byte2", rv, 32'h33);
    rdReg(6'h04, rv); chk("R6 byte3 not overwritten", rv, 32'h44);
    rdReg(6'h04, rv); chk("R5 empty read", rv, 0);
    rdReg(6'h1C, rv); chk("R5 level stays 0", rv, 0);

    // R8 sticky flags
    wrReg(6'h10, 32'h10);
    rdReg(6'h10, rv); chk("R8 ovf cleared", rv & 32'h1C, 0);
    @(negedge clk); evtNack = 1'b1; @(negedge clk); evtNack = 1'b0;
    rdReg(6'h10, rv); chk("R8 nack set", rv & 32'h1C, 32'h04);
    wrReg(6'h10, 32'h0);
    rdReg(6'h10, rv); chk("R8 write 0 keeps", rv & 32'h1C, 32'h04);
    @(negedge clk); evtArbLost = 1'b1; @(negedge clk); evtArbLost = 1'b0;
    wrReg(6'h10, 32'h04);
    rdReg(6'h10, rv); chk("R8 nack cleared arb kept", rv & 32'h1C, 32'h08);
    wrReg(6'h10, 32'h08);
    rdReg(6'h10, rv); chk("R8 arb cleared", rv & 32'h1C, 0);

    // R9 interrupt combine
    wrReg(6'h0C, 32'h04);
    chk("R9 masked off", 32'(irq), 0);
    @(negedge clk); evtNack = 1'b1; @(negedge clk); evtNack = 1'b0;
    chk("R9 nack irq", 32'(irq), 1);
    wrReg(6'h10, 32'h04);
    chk("R9 nack irq clear", 32'(irq), 0);
    wrReg(6'h0C, 32'h01);
    chk("R9 txrdy irq", 32'(irq), 1);
    wrReg(6'h0C, 32'h02);
    chk("R9 rx empty no irq", 32'(irq), 0);
    pushRx(8'h9C);
    chk("R9 rxrdy irq", 32'(irq), 1);
    wrReg(6'h0C, 32'h00);
    chk("R9 all masked", 32'(irq), 0);
    rdReg(6'h0C, rv); chk("R9 ien rd", rv, 0);

    // R11 busy status
    engBusy = 1'b1;
    rdReg(6'h14, rv); chk("R11 busy", rv, 1);
    engBusy = 1'b0;
    rdReg(6'h14, rv); chk("R11 idle", rv, 0);

    // R7 threshold sweep
    for (int t = 0; t < 4; t++) begin
      wrReg(6'h08, 32'h0);
      wrReg(6'h08, 32'h1 | (t << 2) | (t << 4));
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
        rdReg(6'h10, rv);
        chk($sformatf("R7 txrdy t=%0d lvl=%0d", t, lvl), rv & 32'h1, (lvl <= t) ? 1 : 0);
        chk($sformatf("R7 rxrdy t=%0d lvl=%0d", t, lvl), (rv >> 1) & 32'h1, (lvl > t) ? 1 : 0);
        if (lvl < DEPTH) begin
          wrReg(6'h00, 32'(lvl));
          pushRx(8'(lvl));
        end
      end
    end
    wrReg(6'h08, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule